// File: doc/BRIEF.md
# Boot ROM Overlay Memory Decoder

This block decodes the bus of an 8-bit coprocessor with a 16-bit address space. It sends each bus cycle to one of three targets: a behavioural RAM, a small boot ROM, or a 16-byte window of host-communication registers. A single paging flip-flop picks the read mapping. After reset the boot image answers every read at every address, mirrored every 2 KB, while writes still fill RAM. Boot code can therefore copy itself into RAM before it reaches the host link.

The first access of either direction to the register window clears the paging flip-flop. From then on, reads outside the window return RAM. Window accesses never touch RAM. Each one raises a registered one-cycle select strobe, together with its direction and the low four address bits, for the register block that sits beside this decoder. Read data is registered and appears one cycle after the access.

Top module: `bootOverlayDecoder`

## Requirements
- R1: After reset, `overlayOn` is 1, `winSel` and `winWr` are 0, and `rdData` is 0x00.
- R2: While `overlayOn` is 1, a read outside the window returns the ROM byte at index i = addr[10:0]. The ROM byte is i[7:0] XOR {i[10:8], 5'b01011}, so the image repeats every 2 KB across the whole space.
- R3: A write outside the window stores `busWdata` in RAM in both modes, including while the overlay is on.
- R4: A read or a write whose address lies in 0xFEF0 to 0xFEFF clears `overlayOn` on the clock edge that ends that access. Every later read outside the window returns RAM data.
- R5: A write in the window never changes RAM.
- R6: One cycle after a window access, `winSel` is 1, `winWr` equals the access direction (1 = write), and `winAddr` equals addr[3:0]. After a cycle with no window access, `winSel` and `winWr` are 0.
- R7: A read in the window returns the `winRdata` value that was present during the access, in either mode.
- R8: `rdData` changes only on the clock edge after a read. It holds its value through idle cycles and write cycles.
- R9: Once cleared, `overlayOn` stays 0 until reset. A new reset sets it to 1 again and restores ROM reads.
- R10: The behavioural RAM holds 2^RAM_AW bytes (2048 by default), indexed by addr[RAM_AW-1:0] and aliased across the address space. For example, 0x0123 and 0x0923 name the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A bus cycle is present this clock |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 8 | Write data |
| winRdata | input | 8 | Data from the register window for reads in it |
| rdData | output | 8 | Registered read data, one cycle after a read |
| winSel | output | 1 | One-cycle select strobe for the register window |
| winWr | output | 1 | Direction of the strobed window access |
| winAddr | output | 4 | Register index of the strobed window access |
| overlayOn | output | 1 | 1 while reads are served by the boot ROM |

## Verification
A paging flip-flop stuck in the wrong state shows up on the cycle after the next read outside the window. That read returns a ROM pattern where RAM data is expected, or the reverse. The checks use RAM values that cannot match the ROM formula at those addresses, so the two cases are always distinguishable. A decode fault that lets a window write reach RAM only shows when the aliased RAM byte is read back later. The bench therefore preloads that byte and reads it back right after the window write.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef struct packed {
    logic readEn;
    logic ramWe;
    logic pickWin;
    logic pickRom;
  } ctlStrobe_t;
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFEF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        ctl,
  output logic              winSel,
  output logic              winWr,
  output logic [WIN_AW-1:0] winAddr,
  output logic              overlayOn
);
  localparam int TAG_W = ADDR_W - WIN_AW;

  logic inWin;
  logic winAccess;

  assign inWin     = (busAddr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign winAccess = busValid & inWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overlayOn <= 1'b1;
      winSel    <= 1'b0;
      winWr     <= 1'b0;
      winAddr   <= '0;
    end else begin
      if (winAccess) overlayOn <= 1'b0;
      winSel <= winAccess;
      winWr  <= winAccess & busWr;
      if (winAccess) winAddr <= busAddr[WIN_AW-1:0];
    end
  end

  always_comb begin
    ctl.readEn  = busValid & ~busWr;
    ctl.ramWe   = busValid & busWr & ~inWin;
    ctl.pickWin = inWin;
    ctl.pickRom = overlayOn & ~inWin;
  end

  logic [TAG_W-1:0] tagUnused;
  assign tagUnused = '0;

  a_r4_clear_on_window: assert property (@(posedge clk) disable iff (!rstN)
    winAccess |=> !overlayOn);
  a_r9_overlay_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !overlayOn |=> !overlayOn);
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rstN)
    winAccess |=> winSel);
  a_r6_strobe_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !winAccess |=> !winSel);
  a_r6_dir_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    winWr |-> winSel);
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int RAM_AW = 11,
  parameter int ROM_AW = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [RAM_AW-1:0] ramIdx,
  input  logic [ROM_AW-1:0] romIdx,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] winRdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] ramArr [RAM_DEPTH];
  logic [DATA_W-1:0] romData;
  logic [DATA_W-1:0] nextRd;

  // Boot image computed from the index: low byte mixed with the top bits.
  assign romData = romIdx[7:0] ^ {romIdx[ROM_AW-1 -: 3], 5'b01011};

  always_ff @(posedge clk) begin
    if (ctl.ramWe) ramArr[ramIdx] <= busWdata;
  end

  always_comb begin
    if (ctl.pickWin)      nextRd = winRdata;
    else if (ctl.pickRom) nextRd = romData;
    else                  nextRd = ramArr[ramIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (ctl.readEn) rdData <= nextRd;
  end

  a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.readEn |=> $stable(rdData));
  a_r7_window_data: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readEn && ctl.pickWin) |=> rdData == $past(winRdata));
endmodule

// File: rtl/bootOverlayDecoder.sv
module bootOverlayDecoder
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11,
  parameter int ROM_AW = 11,
  parameter int WIN_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] winRdata,
  output logic [DATA_W-1:0] rdData,
  output logic              winSel,
  output logic              winWr,
  output logic [WIN_AW-1:0] winAddr,
  output logic              overlayOn
);
  ctlStrobe_t ctl;

  ovl_ctrl #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWr(busWr),
    .busAddr(busAddr), .ctl(ctl), .winSel(winSel), .winWr(winWr),
    .winAddr(winAddr), .overlayOn(overlayOn)
  );

  ovl_datapath #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ramIdx(busAddr[RAM_AW-1:0]), .romIdx(busAddr[ROM_AW-1:0]),
    .busWdata(busWdata), .winRdata(winRdata), .rdData(rdData)
  );
endmodule

// File: tb/sim_bootOverlayDecoder.sv
module sim_bootOverlayDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  winRdata = '0;
  logic [7:0]  rdData;
  logic        winSel, winWr, overlayOn;
  logic [3:0]  winAddr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bootOverlayDecoder u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .winRdata(winRdata),
    .rdData(rdData), .winSel(winSel), .winWr(winWr), .winAddr(winAddr),
    .overlayOn(overlayOn)
  );

  function automatic logic [7:0] romExp(logic [15:0] a);
    return a[7:0] ^ {a[10:8], 5'b01011};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle; outputs sampled 1 ns after the edge that ends it.
  task automatic cyc(logic v, logic w, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busValid = v; busWr = w; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1; rstN = 1'b1;
  endtask

  task automatic tResetState();
    check("R1 overlayOn", {7'b0, overlayOn}, 8'h01);
    check("R1 winSel", {7'b0, winSel}, 8'h00);
    check("R1 winWr", {7'b0, winWr}, 8'h00);
    check("R1 rdData", rdData, 8'h00);
  endtask

  task automatic tMirrorReads();
    logic [15:0] addrs [5] = '{16'h0000, 16'h1234, 16'hF800, 16'hFFFF, 16'h7ABC};
    foreach (addrs[k]) begin
      cyc(1, 0, addrs[k], 8'h00);
      check("R2 mirrored rom read", rdData, romExp(addrs[k]));
    end
  endtask

  task automatic tOverlayWrites();
    cyc(1, 1, 16'h0100, 8'hA5);
    cyc(1, 1, 16'h0201, 8'h3C);
    cyc(1, 0, 16'h0100, 8'h00);
    check("R2 rom still read after write", rdData, romExp(16'h0100));
    check("R9 overlay kept by ram write", {7'b0, overlayOn}, 8'h01);
  endtask

  task automatic tSwitchOver();
    cyc(1, 1, 16'hFEF3, 8'h42);
    check("R6 winSel", {7'b0, winSel}, 8'h01);
    check("R6 winWr", {7'b0, winWr}, 8'h01);
    check("R6 winAddr", {4'b0, winAddr}, 8'h03);
    check("R4 overlay cleared", {7'b0, overlayOn}, 8'h00);
    cyc(0, 0, 16'h0000, 8'h00);
    check("R6 strobe one cycle", {7'b0, winSel}, 8'h00);
    cyc(1, 0, 16'h0100, 8'h00);
    check("R3 ram holds overlay write", rdData, 8'hA5);
    cyc(1, 0, 16'h0201, 8'h00);
    check("R3 ram holds second write", rdData, 8'h3C);
  endtask

  task automatic tWindowIsolation();
    cyc(1, 1, 16'h06F5, 8'h11);
    cyc(1, 1, 16'hFEF5, 8'h99);
    cyc(1, 0, 16'h06F5, 8'h00);
    check("R5 window write spared ram", rdData, 8'h11);
    winRdata = 8'h5A;
    cyc(1, 0, 16'hFEFA, 8'h00);
    check("R7 window read data", rdData, 8'h5A);
    check("R6 read strobe winWr", {7'b0, winWr}, 8'h00);
    check("R6 read strobe winAddr", {4'b0, winAddr}, 8'h0A);
  endtask

  task automatic tHold();
    cyc(1, 0, 16'h0201, 8'h00);
    cyc(0, 0, 16'h0100, 8'h00);
    check("R8 hold on idle", rdData, 8'h3C);
    cyc(1, 1, 16'h0300, 8'hEE);
    check("R8 hold on write", rdData, 8'h3C);
  endtask

  task automatic tAlias();
    cyc(1, 1, 16'h0123, 8'h77);
    cyc(1, 0, 16'h0923, 8'h00);
    check("R10 aliased ram byte", rdData, 8'h77);
  endtask

  task automatic tReReset();
    doReset();
    check("R9 overlay set by reset", {7'b0, overlayOn}, 8'h01);
    cyc(1, 0, 16'h0100, 8'h00);
    check("R9 rom back after reset", rdData, romExp(16'h0100));
    winRdata = 8'hC3;
    cyc(1, 0, 16'hFEF0, 8'h00);
    check("R7 window read in overlay", rdData, 8'hC3);
    check("R4 read access clears overlay", {7'b0, overlayOn}, 8'h00);
    cyc(1, 0, 16'h0100, 8'h00);
    check("R4 ram read after read switch", rdData, 8'hA5);
  endtask

  initial begin
    doReset();
    tResetState();
    tMirrorReads();
    tOverlayWrites();
    tSwitchOver();
    tWindowIsolation();
    tHold();
    tAlias();
    tReReset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule